// File: doc/BRIEF.md
# Dual Q15 Fractional Multiply Unit

This block is the two-lane multiplier of a packed-media coprocessor. Each of its two 32-bit source operands carries a pair of signed 16-bit halves. The block forms two signed 32-bit products, called left and right, from a selectable pairing of those halves. It then either returns the raw integer products or treats the halves as Q15 fractions. In the Q15 case each product is doubled and may be rounded under control of a small configuration word.

The Q15 results leave the block in one of two shapes. The extended shape writes both 32-bit words. The packed shape writes a single word that carries the upper 16 bits of each rounded product. Only the packed shape has a round-half-to-even option.

The datapath has two registered stages: the first multiplies, and the second scales, rounds and packs. A result appears two clock edges after its operands are accepted, together with `out_valid`. The second stage decides from the carried operation code which of four outcomes it produces: integer, extended, packed or illegal.

Top module: `q15_dual_mul`

## Requirements
- R1: Each source splits into a low lane (bits 15..0) and a high lane (bits 31..16), both signed. `pair_sel` picks the operands as follows. The left product is (`pair_sel[0]` ? a.low : a.high) × b.high. The right product is (`pair_sel[1]` ? a.high : a.low) × b.low.
- R2: With `mode` = 00 (integer), `dst0` is the exact signed 32-bit left product and `dst1` the right product, with no shift and no rounding, and `dst1_wr` is 1.
- R3: With `mode` = 01 (fractional extended), each product is shifted left by one bit. When `rnd_cfg[1]` is 0 the doubled values are returned truncated, whatever `rnd_cfg[2]` holds.
- R4: In mode 01 with `rnd_cfg[1]` = 1, 0x8000 is added to both doubled products, whatever `rnd_cfg[2]` holds.
- R5: With `mode` = 10 (fractional packed), `dst0` = {left[31:16], right[31:16]} after doubling and rounding. `dst1_wr` stays 0 and `dst1` keeps its previous value.
- R6: In mode 10 with `rnd_cfg[1]` = 1, the bias 0x8000 is always added when `rnd_cfg[2]` = 1. When `rnd_cfg[2]` = 0 it is added unless the low 17 bits of the doubled product equal 0x08000. With `rnd_cfg[1]` = 0 the doubled products are truncated.
- R7: In the fractional modes, 0x8000 × 0x8000 doubles to 0x80000000 without saturation. Rounding then gives 0x80008000.
- R8: A result appears exactly two rising edges after the edge that accepted `in_valid`. `out_valid` is high for that one cycle. With `in_valid` low, the outputs hold and `out_valid` stays low.
- R9: `mode` = 11 produces a one-cycle `illegal_op` pulse in the result slot. In that cycle `out_valid` is low, and `dst0` and `dst1` keep their values.
- R10: Synchronous active-high `rst` clears `out_valid`, `illegal_op`, `dst1_wr`, `dst0` and `dst1` to zero, and it drops any operation already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | 00 integer, 01 fractional extended, 10 fractional packed, 11 illegal |
| pair_sel | input | 2 | Half-pairing selector (R1) |
| rnd_cfg | input | 3 | Bit 1 rounding enable, bit 2 force bias; bit 0 unused |
| src_a | input | 32 | First packed source |
| src_b | input | 32 | Second packed source |
| out_valid | output | 1 | Result words are updated this cycle |
| illegal_op | output | 1 | Pulse for an accepted mode-11 request |
| dst0 | output | 32 | Left product, or the packed word |
| dst1 | output | 32 | Right product (not written in packed mode) |
| dst1_wr | output | 1 | `dst1` was written this cycle |

## Verification
If the operation code or the rounding bits are corrupted between the two stages, the damage shows at the ports in the same result cycle. It appears as a wrong bias in the low half of `dst0`/`dst1`, or as `dst1` changing on a packed result. The tie-detection corner is checked with doubled products whose low 17 bits are exactly 0x08000. It is also checked with the odd neighbour 0x18000, so that a one-bit error in the tie mask changes the packed upper half by one. A valid bit that is lost or duplicated in the pipeline shows within two edges as a missing or extra `out_valid` pulse, or as an `illegal_op` pulse that coincides with a data update.

// File: rtl/q15mul_pkg.sv
package q15mul_pkg;

    typedef enum logic [1:0] {
        OP_INT       = 2'b00,
        OP_FRAC_EXT  = 2'b01,
        OP_FRAC_PACK = 2'b10,
        OP_BAD       = 2'b11
    } op_e;

    localparam int CFG_W        = 3;
    localparam int CFG_RND_BIT  = 1;
    localparam int CFG_BIAS_BIT = 2;
    localparam int NLANE        = 2;
    localparam int LANE_LEFT    = 1;
    localparam int LANE_RIGHT   = 0;

endpackage

// File: rtl/q15mul_operand_sel.sv
module q15mul_operand_sel
    import q15mul_pkg::*;
#(
    parameter  int LANE_W = 16,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic [WORD_W-1:0]             src_a,
    input  logic [WORD_W-1:0]             src_b,
    input  logic [1:0]                    pair_sel,
    output logic [NLANE-1:0][LANE_W-1:0]  op_a,
    output logic [NLANE-1:0][LANE_W-1:0]  op_b
);

    logic [LANE_W-1:0] a_lo, a_hi, b_lo, b_hi;

    assign a_lo = src_a[LANE_W-1:0];
    assign a_hi = src_a[WORD_W-1:LANE_W];
    assign b_lo = src_b[LANE_W-1:0];
    assign b_hi = src_b[WORD_W-1:LANE_W];

    // Left lane always takes the high half of b, right lane the low half.
    always_comb begin
        op_a[LANE_LEFT]  = pair_sel[0] ? a_lo : a_hi;
        op_b[LANE_LEFT]  = b_hi;
        op_a[LANE_RIGHT] = pair_sel[1] ? a_hi : a_lo;
        op_b[LANE_RIGHT] = b_lo;
    end

endmodule

// File: rtl/q15mul_mul_stage.sv
module q15mul_mul_stage
    import q15mul_pkg::*;
#(
    parameter  int LANE_W = 16,
    localparam int PROD_W = 2 * LANE_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [1:0]                    in_op,
    input  logic [CFG_W-1:0]              in_cfg,
    input  logic [NLANE-1:0][LANE_W-1:0]  op_a,
    input  logic [NLANE-1:0][LANE_W-1:0]  op_b,
    output logic                          s1_valid,
    output logic [1:0]                    s1_op,
    output logic [CFG_W-1:0]              s1_cfg,
    output logic [NLANE-1:0][PROD_W-1:0]  s1_prod
);

    logic [NLANE-1:0][PROD_W-1:0] prod_d;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [PROD_W-1:0] ext_a, ext_b;
        // Sign extension to full product width keeps the low PROD_W bits exact.
        assign ext_a     = {{LANE_W{op_a[g][LANE_W-1]}}, op_a[g]};
        assign ext_b     = {{LANE_W{op_b[g][LANE_W-1]}}, op_b[g]};
        assign prod_d[g] = ext_a * ext_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= in_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            s1_op   <= in_op;
            s1_cfg  <= in_cfg;
            s1_prod <= prod_d;
        end
    end

endmodule

// File: rtl/q15mul_scale_round.sv
module q15mul_scale_round #(
    parameter  int LANE_W = 16,
    localparam int PROD_W = 2 * LANE_W
) (
    input  logic [PROD_W-1:0] prod,
    input  logic              frac,
    input  logic              rnd_en,
    input  logic              tie_even,
    output logic [PROD_W-1:0] res
);

    localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (LANE_W - 1);

    logic [PROD_W-1:0] scaled;
    logic              is_tie;
    logic              add_bias;

    always_comb begin
        scaled   = frac ? {prod[PROD_W-2:0], 1'b0} : prod;
        // Exact half with an even kept LSB: bit LANE_W clear, lower bits = HALF.
        is_tie   = (scaled[LANE_W:0] == HALF[LANE_W:0]);
        add_bias = frac && rnd_en && !(tie_even && is_tie);
        res      = add_bias ? (scaled + HALF) : scaled;
    end

endmodule

// File: rtl/q15_dual_mul.sv
module q15_dual_mul
    import q15mul_pkg::*;
#(
    parameter  int LANE_W = 16,
    localparam int WORD_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [1:0]        pair_sel,
    input  logic [2:0]        rnd_cfg,
    input  logic [WORD_W-1:0] src_a,
    input  logic [WORD_W-1:0] src_b,
    output logic              out_valid,
    output logic              illegal_op,
    output logic [WORD_W-1:0] dst0,
    output logic [WORD_W-1:0] dst1,
    output logic              dst1_wr
);

    logic [NLANE-1:0][LANE_W-1:0] op_a, op_b;
    logic                         s1_valid;
    logic [1:0]                   s1_op;
    logic [CFG_W-1:0]             s1_cfg;
    logic [NLANE-1:0][WORD_W-1:0] s1_prod;
    logic [NLANE-1:0][WORD_W-1:0] lane_res;
    op_e                          s1_kind;
    logic                         frac, rnd_en, tie_even;

    q15mul_operand_sel #(.LANE_W(LANE_W)) sel_i (
        .src_a    (src_a),
        .src_b    (src_b),
        .pair_sel (pair_sel),
        .op_a     (op_a),
        .op_b     (op_b)
    );

    q15mul_mul_stage #(.LANE_W(LANE_W)) mul_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_op    (mode),
        .in_cfg   (rnd_cfg),
        .op_a     (op_a),
        .op_b     (op_b),
        .s1_valid (s1_valid),
        .s1_op    (s1_op),
        .s1_cfg   (s1_cfg),
        .s1_prod  (s1_prod)
    );

    assign s1_kind  = op_e'(s1_op);
    assign frac     = (s1_kind == OP_FRAC_EXT) || (s1_kind == OP_FRAC_PACK);
    assign rnd_en   = s1_cfg[CFG_RND_BIT];
    assign tie_even = (s1_kind == OP_FRAC_PACK) && !s1_cfg[CFG_BIAS_BIT];

    for (genvar g = 0; g < NLANE; g++) begin : g_round
        q15mul_scale_round #(.LANE_W(LANE_W)) rnd_i (
            .prod     (s1_prod[g]),
            .frac     (frac),
            .rnd_en   (rnd_en),
            .tie_even (tie_even),
            .res      (lane_res[g])
        );
    end

    // Output-stage next values, chosen by the carried operation kind.
    logic              nxt_valid, nxt_ill, nxt_wr;
    logic [WORD_W-1:0] nxt_d0, nxt_d1;

    always_comb begin
        nxt_valid = 1'b0;
        nxt_ill   = 1'b0;
        nxt_wr    = 1'b0;
        nxt_d0    = dst0;
        nxt_d1    = dst1;
        if (s1_valid) begin
            unique case (s1_kind)
                OP_INT, OP_FRAC_EXT: begin
                    nxt_valid = 1'b1;
                    nxt_wr    = 1'b1;
                    nxt_d0    = lane_res[LANE_LEFT];
                    nxt_d1    = lane_res[LANE_RIGHT];
                end
                OP_FRAC_PACK: begin
                    nxt_valid = 1'b1;
                    nxt_d0    = {lane_res[LANE_LEFT][WORD_W-1:LANE_W],
                                 lane_res[LANE_RIGHT][WORD_W-1:LANE_W]};
                end
                OP_BAD: begin
                    nxt_ill = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            illegal_op <= 1'b0;
            dst1_wr    <= 1'b0;
            dst0       <= '0;
            dst1       <= '0;
        end else begin
            out_valid  <= nxt_valid;
            illegal_op <= nxt_ill;
            dst1_wr    <= nxt_wr;
            dst0       <= nxt_d0;
            dst1       <= nxt_d1;
        end
    end

endmodule

// File: rtl/q15mul_chk.sv
module q15mul_chk #(
    parameter  int LANE_W = 16,
    localparam int WORD_W = 2 * LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        mode,
    input logic [1:0]        pair_sel,
    input logic [WORD_W-1:0] src_a,
    input logic [WORD_W-1:0] src_b,
    input logic              out_valid,
    input logic              illegal_op,
    input logic [WORD_W-1:0] dst0,
    input logic [WORD_W-1:0] dst1,
    input logic              dst1_wr
);

    logic [1:0]        age;
    logic              take_ok, take_bad, int_hh;
    logic [WORD_W-1:0] ref_hh;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assign take_ok  = in_valid && (mode != 2'b11);
    assign take_bad = in_valid && (mode == 2'b11);
    assign int_hh   = in_valid && (mode == 2'b00) && (pair_sel == 2'b00);
    assign ref_hh   = {{LANE_W{src_a[WORD_W-1]}}, src_a[WORD_W-1:LANE_W]}
                    * {{LANE_W{src_b[WORD_W-1]}}, src_b[WORD_W-1:LANE_W]};

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(take_ok, 2)));                    // R8

    AST_ILLEGAL_SLOT: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (illegal_op == $past(take_bad, 2)));                  // R9

    AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && illegal_op) |-> ($stable(dst0) && $stable(dst1) && !out_valid)); // R9

    AST_DST1_KEPT: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && !dst1_wr) |-> $stable(dst1));                           // R5

    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        dst1_wr |-> out_valid);                                                 // R2

    AST_INT_LEFT_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && $past(int_hh, 2)) |-> (dst0 == $past(ref_hh, 2)));      // R2

endmodule

bind q15_dual_mul q15mul_chk #(.LANE_W(LANE_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .mode       (mode),
    .pair_sel   (pair_sel),
    .src_a      (src_a),
    .src_b      (src_b),
    .out_valid  (out_valid),
    .illegal_op (illegal_op),
    .dst0       (dst0),
    .dst1       (dst1),
    .dst1_wr    (dst1_wr)
);

// File: tb/q15_dual_mul_tb.sv
module q15_dual_mul_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  mode;
    logic [1:0]  pair_sel;
    logic [2:0]  rnd_cfg;
    logic [31:0] src_a, src_b;
    logic        out_valid, illegal_op, dst1_wr;
    logic [31:0] dst0, dst1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    q15_dual_mul dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .mode       (mode),
        .pair_sel   (pair_sel),
        .rnd_cfg    (rnd_cfg),
        .src_a      (src_a),
        .src_b      (src_b),
        .out_valid  (out_valid),
        .illegal_op (illegal_op),
        .dst0       (dst0),
        .dst1       (dst1),
        .dst1_wr    (dst1_wr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge with an empty pipeline; returns at the
    // falling edge after the second rising edge, where the result sits.
    task automatic run_op(input logic [1:0] m, input logic [1:0] p, input logic [2:0] c,
                          input logic [31:0] a, input logic [31:0] b);
        in_valid = 1'b1; mode = m; pair_sel = p; rnd_cfg = c; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0; src_a = 32'hDEAD_BEEF; src_b = 32'h1234_5678;
        check("R8 no result after one edge", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R10 reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R10 reset illegal_op", {31'd0, illegal_op}, 32'd0);
        check("R10 reset dst0", dst0, 32'd0);
        check("R10 reset dst1", dst1, 32'd0);
        check("R10 reset dst1_wr", {31'd0, dst1_wr}, 32'd0);
    endtask

    task automatic t_pairing;
        // a.hi=3 a.lo=-2, b.hi=7 b.lo=5
        logic [31:0] exp_l [4];
        logic [31:0] exp_r [4];
        exp_l[0] = 32'd21;          exp_r[0] = 32'hFFFF_FFF6;
        exp_l[1] = 32'hFFFF_FFF2;   exp_r[1] = 32'hFFFF_FFF6;
        exp_l[2] = 32'd21;          exp_r[2] = 32'd15;
        exp_l[3] = 32'hFFFF_FFF2;   exp_r[3] = 32'd15;
        for (int p = 0; p < 4; p++) begin
            run_op(2'b00, 2'(p), 3'b110, 32'h0003_FFFE, 32'h0007_0005);
            check($sformatf("R1 R2 pairing %0d left", p), dst0, exp_l[p]);
            check($sformatf("R1 R2 pairing %0d right", p), dst1, exp_r[p]);
            check("R2 out_valid", {31'd0, out_valid}, 32'd1);
            check("R2 dst1_wr", {31'd0, dst1_wr}, 32'd1);
        end
    endtask

    task automatic t_frac_ext;
        run_op(2'b01, 2'b00, 3'b000, 32'h4000_0001, 32'h4000_4000);
        check("R3 trunc left", dst0, 32'h2000_0000);
        check("R3 trunc right", dst1, 32'h0000_8000);
        run_op(2'b01, 2'b00, 3'b100, 32'h4000_0001, 32'h4000_4000);
        check("R3 bias bit alone no effect", dst1, 32'h0000_8000);
        run_op(2'b01, 2'b00, 3'b010, 32'h4000_0001, 32'h4000_4000);
        check("R4 round left", dst0, 32'h2000_8000);
        check("R4 round right tie goes up", dst1, 32'h0001_0000);
        run_op(2'b01, 2'b00, 3'b110, 32'h4000_FFFF, 32'h4000_4000);
        check("R4 round with bias bit", dst0, 32'h2000_8000);
        check("R4 round negative to zero", dst1, 32'h0000_0000);
    endtask

    task automatic t_packed;
        logic [31:0] keep;
        run_op(2'b00, 2'b00, 3'b000, 32'h0005_0006, 32'h0001_0001);
        keep = dst1;
        // left doubled 0x08000 (even tie), right doubled 0x18000 (odd tie)
        run_op(2'b10, 2'b00, 3'b000, 32'h0001_0003, 32'h4000_4000);
        check("R6 packed truncate", dst0, 32'h0000_0001);
        check("R5 dst1 kept", dst1, keep);
        check("R5 dst1_wr low", {31'd0, dst1_wr}, 32'd0);
        check("R5 out_valid", {31'd0, out_valid}, 32'd1);
        run_op(2'b10, 2'b00, 3'b010, 32'h0001_0003, 32'h4000_4000);
        check("R6 round to even", dst0, 32'h0000_0002);
        run_op(2'b10, 2'b00, 3'b110, 32'h0001_0003, 32'h4000_4000);
        check("R6 forced bias", dst0, 32'h0001_0002);
        check("R5 dst1 still kept", dst1, keep);
    endtask

    task automatic t_wrap;
        run_op(2'b00, 2'b00, 3'b000, 32'h8000_8000, 32'h8000_8000);
        check("R7 integer min*min", dst0, 32'h4000_0000);
        run_op(2'b01, 2'b00, 3'b000, 32'h8000_8000, 32'h8000_8000);
        check("R7 fractional wrap left", dst0, 32'h8000_0000);
        check("R7 fractional wrap right", dst1, 32'h8000_0000);
        run_op(2'b01, 2'b00, 3'b010, 32'h8000_8000, 32'h8000_8000);
        check("R7 wrap then round", dst0, 32'h8000_8000);
        run_op(2'b10, 2'b00, 3'b010, 32'h8000_8000, 32'h8000_8000);
        check("R7 packed wrap", dst0, 32'h8000_8000);
    endtask

    task automatic t_idle;
        logic [31:0] d0, d1;
        run_op(2'b00, 2'b00, 3'b000, 32'h0002_0002, 32'h0003_0004);
        d0 = dst0; d1 = dst1;
        for (int i = 0; i < 3; i++) begin
            mode = 2'(i); src_a = 32'h7777_0000 + i; src_b = 32'h1111_2222;
            @(negedge clk);
            check("R8 idle no valid", {31'd0, out_valid}, 32'd0);
            check("R8 idle dst0 hold", dst0, d0);
            check("R8 idle dst1 hold", dst1, d1);
        end
    endtask

    task automatic t_illegal;
        logic [31:0] d0, d1;
        d0 = dst0; d1 = dst1;
        run_op(2'b11, 2'b00, 3'b010, 32'h1234_4321, 32'h0101_0202);
        check("R9 illegal pulse", {31'd0, illegal_op}, 32'd1);
        check("R9 no out_valid", {31'd0, out_valid}, 32'd0);
        check("R9 dst0 unchanged", dst0, d0);
        check("R9 dst1 unchanged", dst1, d1);
        @(negedge clk);
        check("R9 pulse one cycle", {31'd0, illegal_op}, 32'd0);
    endtask

    task automatic t_back2back;
        in_valid = 1'b1; mode = 2'b00; pair_sel = 2'b00; rnd_cfg = 3'b000;
        src_a = 32'h0002_0003; src_b = 32'h0004_0005;
        @(negedge clk);
        src_a = 32'hFFFF_0007; src_b = 32'h0006_0002;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 first of pair valid", {31'd0, out_valid}, 32'd1);
        check("R8 first of pair left", dst0, 32'd8);
        check("R8 first of pair right", dst1, 32'd15);
        @(negedge clk);
        check("R8 second of pair valid", {31'd0, out_valid}, 32'd1);
        check("R8 second of pair left", dst0, 32'hFFFF_FFFA);
        check("R8 second of pair right", dst1, 32'd14);
        @(negedge clk);
    endtask

    task automatic t_reset_mid;
        in_valid = 1'b1; mode = 2'b00; src_a = 32'h0003_0003; src_b = 32'h0003_0003;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        @(negedge clk);
        check("R10 in-flight op dropped", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; mode = 2'b00; pair_sel = 2'b00;
        rnd_cfg = 3'b000; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_pairing();
        t_frac_ext();
        t_packed();
        t_wrap();
        t_idle();
        t_illegal();
        t_back2back();
        t_reset_mid();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule